// File: doc/BRIEF.md
# Prescaled Counter PWM Generator

This block drives one pulse-width modulated output from a single free-running counter. The counter advances once per slow tick, which the surrounding chip supplies as a one-cycle enable pulse at about 32 kHz. The period is not held in a register. Instead, a two-bit prescale code chooses which counter bit clears the counter as soon as that bit would become set. The counter bits below the chosen bit form the active count, and the output stays high while the active count is below a programmed duty value.

Software sees two byte-wide locations on a plain write-enable / address / data bus. The settings location holds the run bit and the prescale code. The duty location holds a seven-bit duty value. Every setting acts on the next clock. The counter is not restarted and the current period is not finished first, so a change made in the middle of a period can shorten or stretch that period.

Top module: `tickpwm_top`

## Requirements
- R1: After a synchronous active-low reset, both locations read 0, the output is low and the counter is zero.
- R2: Address 0 holds the run bit in data bit 7 and the prescale code in bits 1:0, and its other bits read 0. Address 1 holds the duty value in bits 6:0, and its bit 7 reads 0. A read returns the stored value in the same cycle.
- R3: While running, the counter changes only on a clock where the tick is high. On such a clock it takes the value count+1, or clears to 0 when bit (7 − code) of count+1 is set. A period is therefore 2^(7−code) ticks long: 128, 64, 32 or 16.
- R4: While running, the output is high exactly when the active count, which is count bits (6 − code):0, is below the duty value.
- R5: A duty value of 0 keeps the output low. A duty value at or above full scale keeps it high: code 1 with duty 64 never goes low. Code 0 cannot reach 100 %, and duty 127 still gives one low tick per period.
- R6: While the run bit is 0, the output is low and the counter is held at 0. A restart therefore begins the period at count 0.
- R7: A new duty value changes the output on the clock after the write, without waiting for the period to end.
- R8: Writing a new prescale code does not clear the counter. The old count carries on under the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle count enable at the slow PWM rate |
| bus_wr | input | 1 | Write strobe for the byte bus |
| bus_addr | input | 1 | Location select: 0 settings, 1 duty |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected location |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 2-bit prescale code and a byte-wide bus. It pulses the tick on every third clock, so even a full 128-tick period at code 0 fits in a few hundred cycles, and the bench can measure the period at all four codes. A behavioural model tracks the count, settings and expected output on every clock. The bench also places writes in the middle of a period to show that a duty change acts at once and that a prescale change keeps the running count. Full-scale and zero duty values, and a restart after stopping, cover the extreme output levels.

// File: rtl/tickpwm_pkg.sv
// Shared constants for the prescaled counter PWM generator.
// Assumes a one-bit location select on the byte bus.
package tickpwm_pkg;
    localparam logic SEL_SETTINGS = 1'b0;
    localparam logic SEL_DUTY     = 1'b1;
endpackage

// File: rtl/tickpwm_regs.sv
// Settings and duty storage with a combinational read port.
// Assumes DATA_W > DUTY_W and DATA_W > PSC_W so that the fields do not overlap.
module tickpwm_regs
    import tickpwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PSC_W  = 2,
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [DUTY_W-1:0] duty_o
);
    logic              run_q;
    logic [PSC_W-1:0]  psc_q;
    logic [DUTY_W-1:0] duty_q;

    // Capture writes into the selected location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            psc_q  <= '0;
            duty_q <= '0;
        end else if (wr_i) begin
            if (sel_i == SEL_SETTINGS) begin
                run_q <= wdata_i[DATA_W-1];
                psc_q <= wdata_i[PSC_W-1:0];
            end else begin
                duty_q <= wdata_i[DUTY_W-1:0];
            end
        end
    end

    // Read mux: unused bits return zero.
    always_comb begin
        rdata_o = '0;
        if (sel_i == SEL_SETTINGS) begin
            rdata_o[DATA_W-1]  = run_q;
            rdata_o[PSC_W-1:0] = psc_q;
        end else begin
            rdata_o[DUTY_W-1:0] = duty_q;
        end
    end

    assign run_o  = run_q;
    assign psc_o  = psc_q;
    assign duty_o = duty_q;

    // R2
    settings_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_SETTINGS) |=> (run_q == $past(wdata_i[DATA_W-1])));
    // R2
    duty_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_DUTY) |=> (duty_q == $past(wdata_i[DUTY_W-1:0])));
endmodule

// File: rtl/tickpwm_count.sv
// Tick-driven counter whose clearing bit is chosen by the prescale code.
// Assumes CNT_W-1 >= 2**PSC_W, so every code selects a bit above bit 0.
module tickpwm_count #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int NUM_PSC = 2 ** PSC_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             wrap;

    // Increment and pick the clearing bit for the current code.
    always_comb begin
        nxt  = cnt_q + 1'b1;
        wrap = 1'b0;
        for (int p = 0; p < NUM_PSC; p++) begin
            if (psc_i == PSC_W'(p)) wrap = nxt[CNT_W-1-p];
        end
    end

    // Count on ticks while running; hold zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (tick_i) cnt_q <= wrap ? '0 : nxt;
    end

    assign cnt_o = cnt_q;

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_q));
    // R3
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i) |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tickpwm_cmp.sv
// Masks the active count bits and compares them with the duty value.
// Assumes DUTY_W = CNT_W-1; the clock is used only by the checks.
module tickpwm_cmp #(
    parameter int CNT_W  = 8,
    parameter int PSC_W  = 2,
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PSC_W-1:0]  psc_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    localparam int NUM_PSC = 2 ** PSC_W;

    logic [DUTY_W-1:0] mask;
    logic [DUTY_W-1:0] active;

    // Active-bit mask for the selected code.
    always_comb begin
        mask = '0;
        for (int p = 0; p < NUM_PSC; p++) begin
            if (psc_i == PSC_W'(p)) mask = {DUTY_W{1'b1}} >> p;
        end
    end

    // High while the active count is below the duty value.
    always_comb begin
        active = cnt_i[DUTY_W-1:0] & mask;
        pwm_o  = run_i && (active < duty_i);
    end

    // R5
    full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && duty_i > mask && cnt_i[CNT_W-1] == 1'b0) |-> pwm_o);
endmodule

// File: rtl/tickpwm_top.sv
// Single-channel PWM generator: register bank, prescaled counter, compare.
// Assumes tick is a one-clock pulse synchronous to clk.
module tickpwm_top #(
    parameter int CNT_W  = 8,
    parameter int PSC_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    localparam int DUTY_W = CNT_W - 1;

    logic              run;
    logic [PSC_W-1:0]  psc;
    logic [DUTY_W-1:0] duty;
    logic [CNT_W-1:0]  cnt;

    tickpwm_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .sel_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .run_o(run), .psc_o(psc), .duty_o(duty)
    );

    tickpwm_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
        .psc_i(psc), .cnt_o(cnt)
    );

    tickpwm_cmp #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .run_i(run), .psc_i(psc),
        .cnt_i(cnt), .duty_i(duty), .pwm_o(pwm_out)
    );

    // R5
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !pwm_out);
    // R6
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);
endmodule

// File: tb/tickpwm_top_test.sv
// Bench for tickpwm_top: behavioural model compared on every clock,
// plus directed checks for each requirement.
module tickpwm_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwm_out;

    int    checks = 0;
    int    errors = 0;
    bit    live = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R4";

    int m_cnt = 0, m_run = 0, m_psc = 0, m_duty = 0;

    tickpwm_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_pwm();
        int mask;
        mask = (1 << (7 - m_psc)) - 1;
        return (m_run != 0 && ((m_cnt & mask) < m_duty)) ? 1 : 0;
    endfunction

    function automatic int exp_rd(input logic sel);
        return (sel == 1'b0) ? ((m_run << 7) | m_psc) : m_duty;
    endfunction

    // Reference model: counter with old settings first, then writes.
    always @(posedge clk) begin
        int n;
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_psc = 0; m_duty = 0;
        end else begin
            if (m_run == 0) m_cnt = 0;
            else if (tick) begin
                n = m_cnt + 1;
                m_cnt = (((n >> (7 - m_psc)) & 1) != 0) ? 0 : n;
            end
            if (bus_wr) begin
                if (bus_addr == 1'b0) begin
                    m_run = int'(bus_wdata[7]);
                    m_psc = int'(bus_wdata[1:0]);
                end else m_duty = int'(bus_wdata[6:0]);
            end
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (live && rst_n) begin
            check(pwm_out == exp_pwm()[0], cur_req, "pwm_out vs model", int'(pwm_out), exp_pwm());
            check(int'(bus_rdata) == exp_rd(bus_addr), "R2", "read data vs model",
                  int'(bus_rdata), exp_rd(bus_addr));
        end
    end

    // Tick source: one pulse every TICK_DIV clocks.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk);
            #1 tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    end

    task automatic bus_write(input logic sel, input logic [7:0] data);
        @(posedge clk);
        #1 bus_wr = 1'b1; bus_addr = sel; bus_wdata = data;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic read_check(input logic sel, input int exp, input string req);
        @(posedge clk);
        #1 bus_addr = sel;
        @(negedge clk);
        check(int'(bus_rdata) == exp, req, "register read", int'(bus_rdata), exp);
    endtask

    task automatic wait_count(input int target);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (m_cnt == target) break;
        end
    endtask

    task automatic period_check(input int code);
        int t0, prev, rises;
        bus_write(1'b1, 8'(1));
        bus_write(1'b0, 8'h80 | 8'(code));
        prev = 1; rises = 0; t0 = 0;
        for (int i = 0; i < 2000 && rises < 2; i++) begin
            @(negedge clk);
            if (pwm_out && prev == 0) begin
                rises++;
                if (rises == 1) t0 = i;
                else check(i - t0 == (1 << (7 - code)) * TICK_DIV, "R3",
                           "period in clocks", i - t0, (1 << (7 - code)) * TICK_DIV);
            end
            prev = int'(pwm_out);
        end
        check(rises == 2, "R3", "two rising edges seen", rises, 2);
    endtask

    task automatic count_lows(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!pwm_out) lows++;
        end
    endtask

    initial begin
        int lows;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        live = 1'b1;
        // R1: reset state
        cur_req = "R1";
        check(pwm_out == 1'b0, "R1", "output after reset", int'(pwm_out), 0);
        read_check(1'b0, 0, "R1");
        read_check(1'b1, 0, "R1");

        // R2: field placement and zero-reading bits
        cur_req = "R2";
        bus_write(1'b0, 8'h7E);
        read_check(1'b0, 2, "R2");
        bus_write(1'b1, 8'hFF);
        read_check(1'b1, 127, "R2");
        bus_write(1'b1, 8'h00);

        // R4: compare across codes and duties
        cur_req = "R4";
        bus_write(1'b1, 8'd40);
        bus_write(1'b0, 8'h80);
        repeat (500) @(negedge clk);
        bus_write(1'b0, 8'h82);
        bus_write(1'b1, 8'd9);
        repeat (300) @(negedge clk);

        // R3: period length per code
        cur_req = "R3";
        for (int c = 0; c < 4; c++) period_check(c);

        // R5: extremes of the duty value
        cur_req = "R5";
        bus_write(1'b1, 8'd64);
        bus_write(1'b0, 8'h81);
        count_lows(400, lows);
        check(lows == 0, "R5", "lows at full scale, code 1", lows, 0);
        bus_write(1'b1, 8'd0);
        count_lows(400, lows);
        check(lows == 0 ? 1'b0 : lows == 400, "R5", "lows at duty 0", lows, 400);
        bus_write(1'b0, 8'h80);
        bus_write(1'b1, 8'd127);
        count_lows(800, lows);
        check(lows > 0, "R5", "code 0 duty 127 not constant high", lows, 1);

        // R6: stop holds low and restart begins at count 0
        cur_req = "R6";
        bus_write(1'b1, 8'd1);
        wait_count(60);
        bus_write(1'b0, 8'h00);
        count_lows(50, lows);
        check(lows == 50, "R6", "lows while stopped", lows, 50);
        bus_write(1'b0, 8'h80);
        @(negedge clk);
        check(pwm_out == 1'b1, "R6", "high right after restart", int'(pwm_out), 1);

        // R7: duty change acts mid-period
        cur_req = "R7";
        bus_write(1'b1, 8'd100);
        wait_count(50);
        check(pwm_out == 1'b1, "R7", "high before duty drop", int'(pwm_out), 1);
        bus_write(1'b1, 8'd10);
        @(negedge clk);
        check(pwm_out == 1'b0, "R7", "low right after duty drop", int'(pwm_out), 0);

        // R8: code change keeps the running count
        cur_req = "R8";
        bus_write(1'b1, 8'd8);
        wait_count(40);
        bus_write(1'b0, 8'h83);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8", "count kept after code change", int'(pwm_out), 0);
        repeat (300) @(negedge clk);

        live = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule